// File: doc/BRIEF.md
# Polyphase Second-Order One-Bit Noise Shaper

This block is a one-bit, second-order delta-sigma modulator whose sample loop is unrolled across `BRANCHES` parallel stages. It runs on a slow core clock. On each slow cycle with `in_valid` high it takes a word of `BRANCHES` consecutive signed samples and returns `BRANCHES` consecutive output bits. The resulting bit stream is identical, bit for bit, to that of a single serial modulator clocked `BRANCHES` times faster and fed the same samples in the same order. An external serializer turns the output word back into a full-rate stream, and an external deserializer builds the input word.

The loop holds two integrators in cascade. The first accumulates the input minus the feedback and has no delay. The second accumulates the first integrator's new value minus the feedback, and its result takes effect only on the next sample, which gives the one-sample loop delay. The quantizer is the sign of the second integrator. Inside one slow cycle, the integrator state produced by stage l feeds stage l+1. The state left after the last stage is registered for the next word. Integrator widths are the sample width plus parameterized guard bits, so that full-scale input does not wrap them.

Top module: `tidsm_core`

## Requirements
- R1: A synchronous `rst` clears both integrators, `out_valid` and `out_bits` to zero. It takes priority over `in_valid` in the same cycle, and that cycle's input word is dropped.
- R2: An output bit of 1 stands for a feedback of +2^(DATA_W-1) and a bit of 0 for -2^(DATA_W-1). A bit is 1 exactly when the second integrator state it is taken from is zero or positive. The first bit after reset is therefore 1, whatever the input.
- R3: Input sample l (l = 0 is the oldest) sits in `in_samples[l*DATA_W +: DATA_W]` as two's complement. Its output bit is `out_bits[l]`, so bit 0 is the oldest.
- R4: `out_valid` and `out_bits` are registered and appear on the clock edge that follows the edge sampling `in_valid` high.
- R5: For any input sequence, the concatenated output bits equal those of a serial reference that, for each sample x, computes b = (s >= 0), v = b ? +FS : -FS, a = a + x - v, s = s + a - v, starting from a = s = 0.
- R6: A cycle with `in_valid` low leaves both integrators and `out_bits` unchanged, drives `out_valid` low, and ignores `in_samples`. The stream resumes as if the gap did not exist.
- R7: Integrator state carries across words, so the first sample of a word continues from the state left by the last sample of the previous word.
- R8: Neither integrator overflows its width for input at the extremes of the sample range (-2^(DATA_W-1) and 2^(DATA_W-1)-1), applied for several words.
- R9: Elaboration stops when `BRANCHES` is below ceil(OSR·BW/core clock) or when the guard widths are inconsistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (full sample rate divided by BRANCHES) |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word strobe |
| in_samples | input | BRANCHES*DATA_W | Consecutive signed samples, oldest in the low slice |
| out_valid | output | 1 | Output word strobe |
| out_bits | output | BRANCHES | Modulated bits, oldest in bit 0 |

## Verification
Two functions can land on the same edge: a synchronous reset and the acceptance of a new input word. The bench holds `rst` high while `in_valid` is high and carries a word with non-zero samples. It then expects cleared outputs, and expects the next word to be modulated from zero state as the serial reference computes it. A second meeting is between an idle cycle and the carry of state across words. Idle cycles with random data on `in_samples` are placed between valid words, and each word after a gap must continue the reference stream exactly.

// File: rtl/tidsm_pkg.sv
package tidsm_pkg;

   // Smallest branch count that keeps the core clock within its limit
   function automatic int unsigned min_branches(input int unsigned osr,
                                                input int unsigned bw_khz,
                                                input int unsigned core_khz);
      return (osr * bw_khz + core_khz - 1) / core_khz;
   endfunction

   // Meaning of a quantizer bit in the feedback path
   typedef enum logic {
      QBIT_NEG = 1'b0,
      QBIT_POS = 1'b1
   } qbit_e;

endpackage

// File: rtl/tidsm_step.sv
// One sample of the second-order loop, purely combinational.
module tidsm_step #(
   parameter int DATA_W = 16,
   parameter int ACC1_W = 24,
   parameter int ACC2_W = 28
) (
   input  logic signed [DATA_W-1:0] x_i,
   input  logic signed [ACC1_W-1:0] acc1_i,
   input  logic signed [ACC2_W-1:0] acc2_i,
   output tidsm_pkg::qbit_e         q_o,
   output logic signed [ACC1_W-1:0] acc1_o,
   output logic signed [ACC2_W-1:0] acc2_o,
   output logic                     ovf_o
);
   import tidsm_pkg::*;

   localparam int XW = ACC2_W + 2;
   localparam logic signed [XW-1:0] FB_POS = XW'(1) <<< (DATA_W - 1);
   localparam logic signed [XW-1:0] FB_NEG = -FB_POS;

   logic signed [XW-1:0] fb;
   logic signed [XW-1:0] x_ext;
   logic signed [XW-1:0] a_old_ext;
   logic signed [XW-1:0] s_old_ext;
   logic signed [XW-1:0] a_sum;
   logic signed [XW-1:0] a_new_ext;
   logic signed [XW-1:0] s_sum;
   logic                 ovf1;
   logic                 ovf2;

   always_comb begin
      q_o       = acc2_i[ACC2_W-1] ? QBIT_NEG : QBIT_POS;
      fb        = (q_o == QBIT_POS) ? FB_POS : FB_NEG;
      x_ext     = {{(XW-DATA_W){x_i[DATA_W-1]}}, x_i};
      a_old_ext = {{(XW-ACC1_W){acc1_i[ACC1_W-1]}}, acc1_i};
      s_old_ext = {{(XW-ACC2_W){acc2_i[ACC2_W-1]}}, acc2_i};
      a_sum     = a_old_ext + x_ext - fb;
      acc1_o    = a_sum[ACC1_W-1:0];
      a_new_ext = {{(XW-ACC1_W){acc1_o[ACC1_W-1]}}, acc1_o};
      s_sum     = s_old_ext + a_new_ext - fb;
      acc2_o    = s_sum[ACC2_W-1:0];
      ovf1      = !((&a_sum[XW-1:ACC1_W-1]) || !(|a_sum[XW-1:ACC1_W-1]));
      ovf2      = !((&s_sum[XW-1:ACC2_W-1]) || !(|s_sum[XW-1:ACC2_W-1]));
      ovf_o     = ovf1 || ovf2;
   end

endmodule

// File: rtl/tidsm_chain.sv
// Unrolled chain: state ripples from stage l to stage l+1 within one cycle.
module tidsm_chain #(
   parameter int BRANCHES = 8,
   parameter int DATA_W   = 16,
   parameter int ACC1_W   = 24,
   parameter int ACC2_W   = 28
) (
   input  logic [BRANCHES*DATA_W-1:0] samples_i,
   input  logic signed [ACC1_W-1:0]   acc1_i,
   input  logic signed [ACC2_W-1:0]   acc2_i,
   output logic [BRANCHES-1:0]        bits_o,
   output logic signed [ACC1_W-1:0]   acc1_o,
   output logic signed [ACC2_W-1:0]   acc2_o,
   output logic                       ovf_o
);
   import tidsm_pkg::*;

   logic signed [ACC1_W-1:0] a_link [BRANCHES+1];
   logic signed [ACC2_W-1:0] s_link [BRANCHES+1];
   logic [BRANCHES-1:0]      ovf_vec;

   assign a_link[0] = acc1_i;
   assign s_link[0] = acc2_i;

   for (genvar g = 0; g < BRANCHES; g++) begin : g_stage
      qbit_e q;
      tidsm_step #(
         .DATA_W (DATA_W),
         .ACC1_W (ACC1_W),
         .ACC2_W (ACC2_W)
      ) u_step (
         .x_i    (samples_i[g*DATA_W +: DATA_W]),
         .acc1_i (a_link[g]),
         .acc2_i (s_link[g]),
         .q_o    (q),
         .acc1_o (a_link[g+1]),
         .acc2_o (s_link[g+1]),
         .ovf_o  (ovf_vec[g])
      );
      assign bits_o[g] = (q == QBIT_POS);
   end

   assign acc1_o = a_link[BRANCHES];
   assign acc2_o = s_link[BRANCHES];
   assign ovf_o  = |ovf_vec;

endmodule

// File: rtl/tidsm_core.sv
module tidsm_core #(
   parameter int BRANCHES = 8,
   parameter int DATA_W   = 16,
   parameter int GUARD1   = 8,
   parameter int GUARD2   = 12,
   parameter int OSR      = 100,
   parameter int BW_KHZ   = 8000,
   parameter int CORE_KHZ = 150000
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   input  logic [BRANCHES*DATA_W-1:0]   in_samples,
   output logic                         out_valid,
   output logic [BRANCHES-1:0]          out_bits
);
   import tidsm_pkg::*;

   localparam int ACC1_W   = DATA_W + GUARD1;
   localparam int ACC2_W   = DATA_W + GUARD2;
   localparam int MIN_BR   = int'(min_branches(OSR, BW_KHZ, CORE_KHZ));

   // R9: elaboration-time parameter checks
   if (BRANCHES < 1 || BRANCHES < MIN_BR) begin : g_bad_branches
      $error("tidsm_core: BRANCHES=%0d below required %0d", BRANCHES, MIN_BR);
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("tidsm_core: DATA_W must be at least 2");
   end
   if (GUARD1 < 2 || GUARD2 <= GUARD1) begin : g_bad_guard
      $error("tidsm_core: need GUARD1 >= 2 and GUARD2 > GUARD1");
   end

   logic signed [ACC1_W-1:0] acc1_q;
   logic signed [ACC2_W-1:0] acc2_q;
   logic signed [ACC1_W-1:0] acc1_nx;
   logic signed [ACC2_W-1:0] acc2_nx;
   logic [BRANCHES-1:0]      bits_nx;
   logic                     chain_ovf;

   tidsm_chain #(
      .BRANCHES (BRANCHES),
      .DATA_W   (DATA_W),
      .ACC1_W   (ACC1_W),
      .ACC2_W   (ACC2_W)
   ) u_chain (
      .samples_i (in_samples),
      .acc1_i    (acc1_q),
      .acc2_i    (acc2_q),
      .bits_o    (bits_nx),
      .acc1_o    (acc1_nx),
      .acc2_o    (acc2_nx),
      .ovf_o     (chain_ovf)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc1_q    <= '0;
         acc2_q    <= '0;
         out_bits  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            acc1_q   <= acc1_nx;
            acc2_q   <= acc2_nx;
            out_bits <= bits_nx;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> !chain_ovf); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(acc1_q) && $stable(acc2_q) && $stable(out_bits) && !out_valid)); // R6

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R4

   AST_FIRST_BIT_SIGN: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_bits[0] == !$past(acc2_q[ACC2_W-1]))); // R2

endmodule

// File: tb/tidsm_core_tb.sv
`timescale 1ns/1ps
module tidsm_core_tb;
   localparam int M  = 8;
   localparam int DW = 16;
   localparam longint FS = 64'sd1 <<< (DW - 1);

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic [M*DW-1:0] in_samples = '0;
   logic            out_valid;
   logic [M-1:0]    out_bits;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;
   longint m1 = 0;
   longint m2 = 0;
   logic [M-1:0] exp_bits = '0;
   logic         exp_valid = 1'b0;

   always #2 clk = ~clk;

   tidsm_core u_dut (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_samples (in_samples),
      .out_valid  (out_valid),
      .out_bits   (out_bits)
   );

   // Serial reference of R5, one sample at a time
   function automatic logic [M-1:0] model_word(input logic [M*DW-1:0] w);
      logic [M-1:0] r;
      for (int l = 0; l < M; l++) begin
         logic signed [DW-1:0] xs;
         longint x, v;
         xs   = w[l*DW +: DW];
         x    = longint'(xs);
         r[l] = (m2 >= 0);
         v    = r[l] ? FS : -FS;
         m1   = m1 + x - v;
         m2   = m2 + m1 - v;
      end
      return r;
   endfunction

   function automatic logic [M*DW-1:0] fill_word(input longint val);
      logic [M*DW-1:0] w;
      for (int l = 0; l < M; l++) w[l*DW +: DW] = val[DW-1:0];
      return w;
   endfunction

   function automatic logic [M*DW-1:0] rand_word(input int span);
      logic [M*DW-1:0] w;
      for (int l = 0; l < M; l++) begin
         int v;
         v = int'($urandom_range(2*span - 1, 0)) - span;
         w[l*DW +: DW] = v[DW-1:0];
      end
      return w;
   endfunction

   task automatic check_bits(input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: out_bits=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, check at the next falling edge
   task automatic cycle(input string tag, input logic v, input logic [M*DW-1:0] w, input logic r);
      rst        = r;
      in_valid   = v;
      in_samples = w;
      @(posedge clk);
      @(negedge clk);
      if (r) begin
         m1 = 0; m2 = 0;
         exp_valid = 1'b0;
         exp_bits  = '0;
      end else if (v) begin
         exp_bits  = model_word(w);
         exp_valid = 1'b1;
      end else begin
         exp_valid = 1'b0;
      end
      check_bit(tag, out_valid, exp_valid);
      check_bits(tag, out_bits, exp_bits);
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: run did not complete");
         report();
         $finish;
      end
   end

   initial begin
      logic [M*DW-1:0] w;
      void'($urandom(32'd20240611));
      @(negedge clk);
      // R1: reset state
      for (int i = 0; i < 3; i++) cycle("R1 reset state", 1'b0, '0, 1'b1);

      // R2: first bit after reset is 1 even for most negative input
      cycle("R2 first word -FS", 1'b1, fill_word(-FS), 1'b0);
      check_bit("R2 bit0 after reset", out_bits[0], 1'b1);

      // R3: order-sensitive word, oldest sample in slice 0
      cycle("R1 reset again", 1'b0, '0, 1'b1);
      w = fill_word(FS - 1);
      w[DW-1:0] = DW'(-FS);
      cycle("R3 bit order", 1'b1, w, 1'b0);
      w = fill_word(-FS);
      w[(M-1)*DW +: DW] = DW'(FS - 1);
      cycle("R3 bit order tail", 1'b1, w, 1'b0);

      // R6: idle cycles with junk input, then stream resumes (R7 carry)
      cycle("R6 pre-gap", 1'b1, rand_word(16384), 1'b0);
      for (int i = 0; i < 3; i++) cycle("R6 idle hold", 1'b0, rand_word(32768), 1'b0);
      cycle("R7 resume after gap", 1'b1, rand_word(16384), 1'b0);

      // R1: reset in the same cycle as a valid word
      cycle("R1 reset wins over valid", 1'b1, fill_word(12345), 1'b1);
      cycle("R1 restart from zero", 1'b1, rand_word(20000), 1'b0);

      // R8: full-scale extremes
      cycle("R1 reset pre-burst", 1'b0, '0, 1'b1);
      for (int i = 0; i < 2; i++) cycle("R8 +full scale", 1'b1, fill_word(FS - 1), 1'b0);
      for (int i = 0; i < 4; i++) cycle("R8 settle", 1'b1, fill_word(0), 1'b0);
      cycle("R1 reset mid", 1'b0, '0, 1'b1);
      for (int i = 0; i < 2; i++) cycle("R8 -full scale", 1'b1, fill_word(-FS), 1'b0);
      for (int i = 0; i < 4; i++) cycle("R8 settle", 1'b1, fill_word(0), 1'b0);
      cycle("R1 reset alt", 1'b0, '0, 1'b1);
      for (int i = 0; i < 2; i++) begin
         for (int l = 0; l < M; l++) w[l*DW +: DW] = (l % 2 == 0) ? DW'(FS - 1) : DW'(-FS);
         cycle("R8 alternating extremes", 1'b1, w, 1'b0);
      end
      for (int i = 0; i < 4; i++) cycle("R8 settle", 1'b1, fill_word(0), 1'b0);

      // R5 R7: long random stream with occasional gaps
      cycle("R1 reset pre-random", 1'b0, '0, 1'b1);
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(9, 0) == 0)
            cycle("R6 random gap", 1'b0, rand_word(32768), 1'b0);
         else
            cycle("R5 R7 random stream", 1'b1, rand_word(24576), 1'b0);
      end

      // R4: strobe drops one cycle after in_valid drops
      cycle("R4 valid low", 1'b0, '0, 1'b0);
      done = 1'b1;
      report();
      $finish;
   end

endmodule